// File: doc/BRIEF.md
# Reloadable Down-Counting Event Counter

This block is one channel of a 16-bit event counting timer. Once started, it subtracts one from its counter for every qualified count event. An event is either a chosen transition on an external input pin or a strobe from a neighbouring timer channel. When an event arrives while the counter already reads zero, the counter takes the value held in its reload register and keeps running. The same event raises a one-clock underflow strobe, which acts as the interrupt request. With a programmed value n, one underflow occurs for every n+1 counted events.

A host reaches the block through a small register port with three locations: a control word that holds the start bit, a mode word that holds the source and edge fields, and the data word. While the channel is stopped, a write to the data word sets both the counter and the reload register. While the channel runs, the same write changes only the reload register, and the counter picks up the new value at its next reload. A read of the data word returns the live counter. The underflow strobe can be wired straight to the neighbour input of another channel to build a cascade.

Top module: `evt_down_timer`

## Requirements
- R1: While the start bit is 1, each qualified event with a nonzero counter lowers the counter by exactly one in the following cycle.
- R2: An event that arrives with the counter at zero loads the counter from the reload register. In the next cycle, underflow_o and irq_o are both high for one clock. With a set value n, this gives one underflow per n+1 events, and with n = 0 every event underflows.
- R3: Mode bits [1:0] select the active pin edge: 00 counts rising edges, 01 counts falling edges, and 10 or 11 counts both edges.
- R4: Mode bit 2 selects the count source. 0 selects the pin. 1 selects chain_in, which gives one event for every clock cycle in which chain_in is high.
- R5: Control bit 0 at address 0 is the start bit. While it is 0, events are ignored and the counter holds its value.
- R6: While the channel is stopped, a write to address 2 loads both the counter and the reload register.
- R7: While the channel is running, a write to address 2 updates only the reload register. The counter takes the new value at its next reload.
- R8: A read of address 2 returns the current counter. Address 0 returns the start bit in bit 0, and address 1 returns the mode bits in bits [2:0]. All other bits read as zero.
- R9: The pin passes through a two-stage synchroniser before edge detection. A level that stays on the pin gives exactly one event, and at most one event is counted in each clock.
- R10: A synchronous reset clears the counter, the reload register, the mode bits, the start bit and the underflow strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Register select: 0 control, 1 mode, 2 data |
| host_wr | input | 1 | Write strobe for the selected register |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data of the selected register (combinational) |
| pin_in | input | 1 | Asynchronous external event pin |
| chain_in | input | 1 | Underflow strobe from a neighbouring channel |
| underflow_o | output | 1 | One-clock underflow strobe, usable as a cascade source |
| irq_o | output | 1 | Interrupt request, a one-clock pulse on underflow |

## Verification
The chain source is driven with isolated single-cycle strobes, which show the exact step per event and where the reload falls. It is also held high for several cycles to show that each cycle counts once. The set values 3, 0 and FFFFh separate an ordinary wrap, the every-event underflow case and the top of the range. A running write followed by a full count shows that the new reload value appears only after the wrap. The pin is toggled under each edge mode, so that a rising-only, falling-only or both-edge decode each give a different counter trail, and strobes applied while stopped must leave the counter untouched.

// File: rtl/evt_pkg.sv
package evt_pkg;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_ANY  = 2'b10,
        EDGE_ANY2 = 2'b11
    } edge_sel_e;

    typedef enum logic {
        SRC_PIN   = 1'b0,
        SRC_CHAIN = 1'b1
    } evt_src_e;

    typedef struct packed {
        evt_src_e  src;
        edge_sel_e edg;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_MODE = 2'd1,
        ADDR_DATA = 2'd2
    } reg_addr_e;

    function automatic logic edge_hit(edge_sel_e sel, logic cur, logic prv);
        case (sel)
            EDGE_RISE: return cur & ~prv;
            EDGE_FALL: return ~cur & prv;
            default:   return cur ^ prv;
        endcase
    endfunction

endpackage

// File: rtl/evt_pin_edge.sv
module evt_pin_edge
    import evt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_i,
    input  edge_sel_e edge_sel_i,
    output logic      hit_o
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_q;

    generate
        for (genvar g = 0; g < SH_W; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sh_q[g] <= 1'b0;
                    else     sh_q[g] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sh_q[g] <= 1'b0;
                    else     sh_q[g] <= sh_q[g-1];
                end
            end
        end
    endgenerate

    assign hit_o = edge_hit(edge_sel_i, sh_q[STAGES-1], sh_q[STAGES]);

endmodule

// File: rtl/evt_src_mux.sv
module evt_src_mux
    import evt_pkg::*;
(
    input  evt_src_e src_i,
    input  logic     run_i,
    input  logic     pin_hit_i,
    input  logic     chain_i,
    output logic     evt_o
);
    always_comb begin
        unique case (src_i)
            SRC_CHAIN: evt_o = run_i & chain_i;
            default:   evt_o = run_i & pin_hit_i;
        endcase
    end
endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             evt_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rld_o,
    output logic             uf_o
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] cnt_q, rld_q;
    logic             uf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= ZERO;
            rld_q <= ZERO;
            uf_q  <= 1'b0;
        end else begin
            uf_q <= 1'b0;
            if (load_i) begin
                rld_q <= load_val_i;
                if (!run_i) cnt_q <= load_val_i;
            end
            if (evt_i && run_i) begin
                if (cnt_q == ZERO) begin
                    cnt_q <= rld_q;
                    uf_q  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - ONE;
                end
            end
        end
    end

    assign cnt_o = cnt_q;
    assign rld_o = rld_q;
    assign uf_o  = uf_q;
endmodule

// File: rtl/evt_down_timer.sv
module evt_down_timer
    import evt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       host_addr,
    input  logic             host_wr,
    input  logic [CNT_W-1:0] host_wdata,
    output logic [CNT_W-1:0] host_rdata,
    input  logic             pin_in,
    input  logic             chain_in,
    output logic             underflow_o,
    output logic             irq_o
);
    logic             run_q;
    mode_t            mode_q;
    logic             pin_hit, evt_pulse, data_wr;
    logic [CNT_W-1:0] cnt_val, rld_val;
    logic             uf_w;

    assign data_wr = host_wr && (reg_addr_e'(host_addr) == ADDR_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            mode_q <= '0;
        end else if (host_wr) begin
            case (reg_addr_e'(host_addr))
                ADDR_CTRL: run_q  <= host_wdata[0];
                ADDR_MODE: mode_q <= mode_t'(host_wdata[MODE_W-1:0]);
                default: ;
            endcase
        end
    end

    evt_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
        .clk        (clk),
        .rst        (rst),
        .pin_i      (pin_in),
        .edge_sel_i (mode_q.edg),
        .hit_o      (pin_hit)
    );

    evt_src_mux u_mux (
        .src_i     (mode_q.src),
        .run_i     (run_q),
        .pin_hit_i (pin_hit),
        .chain_i   (chain_in),
        .evt_o     (evt_pulse)
    );

    evt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .run_i      (run_q),
        .evt_i      (evt_pulse),
        .load_i     (data_wr),
        .load_val_i (host_wdata),
        .cnt_o      (cnt_val),
        .rld_o      (rld_val),
        .uf_o       (uf_w)
    );

    always_comb begin
        host_rdata = '0;
        case (reg_addr_e'(host_addr))
            ADDR_CTRL: host_rdata[0] = run_q;
            ADDR_MODE: host_rdata[MODE_W-1:0] = mode_q;
            ADDR_DATA: host_rdata = cnt_val;
            default:   host_rdata = '0;
        endcase
    end

    assign underflow_o = uf_w;
    assign irq_o       = uf_w;
endmodule

// File: rtl/evt_down_timer_chk.sv
module evt_down_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       addr,
    input logic             wr,
    input logic [CNT_W-1:0] wdata,
    input logic             run,
    input logic             evt,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] rld,
    input logic             uf,
    input logic             irq
);
    // R1
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && evt && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));

    // R2
    reload_val_chk: assert property (@(posedge clk) disable iff (rst)
        uf |-> cnt == $past(rld));

    // R2
    uf_cause_chk: assert property (@(posedge clk) disable iff (rst)
        uf |-> $past(run && evt && cnt == '0));

    // R2
    irq_pair_chk: assert property (@(posedge clk) disable iff (rst)
        irq == uf);

    // R5
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !(wr && addr == 2'd2)) |=> $stable(cnt));

    // R6
    stop_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && wr && addr == 2'd2) |=> (cnt == $past(wdata) && rld == $past(wdata)));

    // R7
    run_load_chk: assert property (@(posedge clk) disable iff (rst)
        (run && wr && addr == 2'd2) |=> rld == $past(wdata));

    // R10
    rst_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (cnt == '0 && rld == '0 && !run && !uf));
endmodule

bind evt_down_timer evt_down_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .addr  (host_addr),
    .wr    (host_wr),
    .wdata (host_wdata),
    .run   (run_q),
    .evt   (evt_pulse),
    .cnt   (cnt_val),
    .rld   (rld_val),
    .uf    (underflow_o),
    .irq   (irq_o)
);

// File: tb/evt_down_timer_tb_top.sv
`timescale 1ns/1ps
module evt_down_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  host_addr = 2'd0;
    logic        host_wr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        pin_in = 1'b0;
    logic        chain_in = 1'b0;
    logic        underflow_o, irq_o;

    int checks = 0;
    int errors = 0;
    int uf_seen = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    evt_down_timer dut_i (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .pin_in(pin_in),
        .chain_in(chain_in), .underflow_o(underflow_o), .irq_o(irq_o)
    );

    always @(posedge clk) if (!rst && underflow_o) uf_seen++;

    // R2: irq follows the underflow strobe every cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (irq_o !== underflow_o) begin
                errors++;
                $display("FAIL R2 irq_o=%0b expected %0b", irq_o, underflow_o);
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [15:0] exp);
        @(negedge clk);
        host_addr = a;
        #1;
        chk(tag, host_rdata, exp);
    endtask

    task automatic chain_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); chain_in = 1'b1;
            @(negedge clk); chain_in = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic pin_set(input logic v);
        @(negedge clk); pin_in = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic uf_chk(input string tag, input int exp);
        @(negedge clk);
        checks++;
        if (uf_seen != exp) begin
            errors++;
            $display("FAIL %s underflows actual=%0d expected=%0d", tag, uf_seen, exp);
        end
    endtask

    task automatic t_reset();
        // R10
        chk("R10 underflow_o after reset", {15'b0, underflow_o}, 16'h0);
        rd_chk("R10 data after reset", 2'd2, 16'h0);
        rd_chk("R10 ctrl after reset", 2'd0, 16'h0);
        rd_chk("R10 mode after reset", 2'd1, 16'h0);
    endtask

    task automatic t_stopped();
        wr_reg(2'd1, 16'h0004);
        rd_chk("R8 mode readback", 2'd1, 16'h0004);
        wr_reg(2'd2, 16'd3);
        rd_chk("R6 stopped write loads counter", 2'd2, 16'd3);
        chain_pulses(2);
        rd_chk("R5 events ignored while stopped", 2'd2, 16'd3);
        uf_chk("R5 no underflow while stopped", 0);
    endtask

    task automatic t_chain_wrap();
        wr_reg(2'd0, 16'h0001);
        rd_chk("R8 ctrl readback", 2'd0, 16'h0001);
        chain_pulses(1);
        rd_chk("R1 one step", 2'd2, 16'd2);
        chain_pulses(2);
        rd_chk("R1 reaches zero", 2'd2, 16'd0);
        uf_chk("R2 no underflow before wrap", 0);
        chain_pulses(1);
        rd_chk("R2 reload after n+1 events", 2'd2, 16'd3);
        uf_chk("R2 underflow count after wrap", 1);
    endtask

    task automatic t_run_write();
        wr_reg(2'd2, 16'd1);
        rd_chk("R7 running write leaves counter", 2'd2, 16'd3);
        chain_pulses(4);
        rd_chk("R7 new reload at next wrap", 2'd2, 16'd1);
        uf_chk("R7 underflow at wrap", 2);
        chain_pulses(2);
        rd_chk("R7 period uses new value", 2'd2, 16'd1);
        uf_chk("R7 second underflow", 3);
    endtask

    task automatic t_zero_and_max();
        wr_reg(2'd0, 16'h0000);
        wr_reg(2'd2, 16'd0);
        wr_reg(2'd0, 16'h0001);
        chain_pulses(3);
        uf_chk("R2 n=0 underflows every event", 6);
        wr_reg(2'd0, 16'h0000);
        wr_reg(2'd2, 16'hFFFF);
        wr_reg(2'd0, 16'h0001);
        chain_pulses(1);
        rd_chk("R1 step from FFFF", 2'd2, 16'hFFFE);
        // R4 / R9: chain held high counts one per clock
        @(negedge clk); chain_in = 1'b1;
        repeat (5) @(negedge clk);
        chain_in = 1'b0;
        rd_chk("R4 R9 held chain counts per clock", 2'd2, 16'hFFF9);
        chain_pulses(1);
        pin_set(1'b1);
        pin_set(1'b0);
        rd_chk("R4 pin ignored when chain selected", 2'd2, 16'hFFF8);
    endtask

    task automatic t_pin_edges();
        wr_reg(2'd0, 16'h0000);
        wr_reg(2'd1, 16'h0000);
        wr_reg(2'd2, 16'd10);
        wr_reg(2'd0, 16'h0001);
        chain_pulses(2);
        rd_chk("R4 chain ignored when pin selected", 2'd2, 16'd10);
        pin_set(1'b1);
        rd_chk("R3 rising counted", 2'd2, 16'd9);
        repeat (6) @(negedge clk);
        rd_chk("R9 held level counts once", 2'd2, 16'd9);
        pin_set(1'b0);
        rd_chk("R3 falling ignored in rise mode", 2'd2, 16'd9);
        wr_reg(2'd1, 16'h0001);
        pin_set(1'b1);
        rd_chk("R3 rising ignored in fall mode", 2'd2, 16'd9);
        pin_set(1'b0);
        rd_chk("R3 falling counted", 2'd2, 16'd8);
        wr_reg(2'd1, 16'h0002);
        pin_set(1'b1);
        rd_chk("R3 both mode rise", 2'd2, 16'd7);
        pin_set(1'b0);
        rd_chk("R3 both mode fall", 2'd2, 16'd6);
        wr_reg(2'd0, 16'h0000);
        pin_set(1'b1);
        rd_chk("R5 pin ignored while stopped", 2'd2, 16'd6);
    endtask

    task automatic t_mid_reset();
        wr_reg(2'd0, 16'h0001);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd_chk("R10 data cleared", 2'd2, 16'h0);
        rd_chk("R10 start cleared", 2'd0, 16'h0);
        rd_chk("R10 mode cleared", 2'd1, 16'h0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_stopped();
        t_chain_wrap();
        t_run_write();
        t_zero_and_max();
        t_pin_edges();
        t_mid_reset();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule